// File: doc/BRIEF.md
# Burst-Framed Multi-Lane Serial Receiver

This block receives data-driven burst frames on several serial lanes at once. Each recognised rising edge of the frame sync starts exactly one slot. After a programmable delay of zero, one or two bit clocks, each enabled lane shifts in one word of programmable length, most significant bit first. The word is then placed in that lane's receive buffer and the lane's ready flag is raised. Serial clocks that arrive between slots do nothing. A frame sync edge that arrives while a slot is in progress is also ignored.

The block runs on the serial bit clock. Frame sync and data are sampled on its rising edge, so a sender must launch them on the falling edge. As a slave, the block follows the external frame sync input. As a master, it drives a one-clock frame sync pulse of its own. It issues the next pulse only when no slot is in progress and the host has acknowledged the buffer of every enabled lane. The host reads a buffer at any time and acknowledges it with a one-cycle read strobe. If a lane completes a word while its previous word is still unacknowledged, the new word overwrites the old one and the lane's overrun flag is set.

Top module: `burst_rx`

## Requirements
- R1: A slot starts only on a rising edge of the frame sync (low at one rising clock edge, high at the next). A frame sync held high starts a single slot.
- R2: `cfg_delay` sets the number of clocks between the frame sync edge and the first data bit: 0 samples the first bit at the same clock edge, 1 at the next edge, 2 two edges later. The value 3 behaves as 2.
- R3: `cfg_slot_len` sets the slot length in bits. Values below 8 act as 8 and values above 32 act as 32. The word is assembled MSB first, right-aligned in its 32-bit field, with the unused upper bits zero. Lane i's buffer appears on `rd_data[i*32 +: 32]`.
- R4: Clocks that arrive after a slot completes, with no new frame sync edge, change no buffer, ready flag or overrun flag.
- R5: A frame sync edge that arrives during the delay or the shifting of a slot has no effect: the slot completes unchanged and no second slot follows.
- R6: A lane's ready flag rises on the clock edge that samples the last bit of its slot. It clears on the edge where that lane's `rd_en` bit is high.
- R7: If a slot completes on a lane whose ready flag is still set (and that lane's `rd_en` bit is not high), the buffer takes the new word and the lane's overrun flag is set. A read of that lane clears the flag.
- R8: With `cfg_master` at 1, `fs_out` is a pulse exactly one clock wide, and `fs_in` is ignored.
- R9: In master mode, no new `fs_out` pulse is issued while any lane enabled in `cfg_lane_en` holds an unacknowledged word. A pulse follows within three clocks once the last such word is acknowledged. Lanes that are disabled neither load their buffers nor hold back the frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the frame sync; 0: follow `fs_in` |
| cfg_delay | input | 2 | Clocks from the frame sync edge to the first bit (0..2, 3 acts as 2) |
| cfg_slot_len | input | LEN_W (6) | Slot length in bits, clamped to 8..32 |
| cfg_lane_en | input | LANES (4) | Lanes set as receivers |
| fs_in | input | 1 | External frame sync (slave mode) |
| fs_out | output | 1 | Generated frame sync pulse (master mode) |
| sd_in | input | LANES (4) | Serial data, one bit per lane |
| rd_en | input | LANES (4) | Per-lane read acknowledge strobe |
| rd_data | output | LANES*WORD_W (128) | Receive buffers, lane i at bits i*32 upward |
| rd_ready | output | LANES (4) | Per-lane word-ready flag |
| rd_overrun | output | LANES (4) | Per-lane overwrite flag |

## Verification
On every cycle, the assertions check the following:
- the generated pulse is one clock wide and never appears while a slot is running or an enabled buffer is unread;
- the bit counter stays inside the latched slot length, and the remaining delay stays at most 2;
- a ready flag rises only on a word completion, and an overrun is flagged only over an unread word;
- an ignored frame sync edge leaves the slot's latched length untouched.

Only the bench scenarios can show that the bits land in the right positions for each delay and length, that held or mid-slot frame syncs and idle clocks produce no extra word, that disabled lanes keep their old contents, and that the master releases its next pulse exactly when the last buffer is read.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_WAIT  = 2'd1,
    FR_SHIFT = 2'd2
  } fr_state_e;

  // Delay code 3 is folded onto the longest legal delay.
  function automatic logic [1:0] eff_delay(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // Clamp a requested slot length into the supported window.
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/rx_framer.sv
module rx_framer
  import rxb_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int MIN_LEN = 8,
  parameter int LEN_W   = $clog2(WORD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_src,
  input  logic [1:0]       cfg_delay,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             sample_en,
  output logic             first_bit,
  output logic             last_bit,
  output logic             busy,
  output logic             fs_evt,
  output logic             fs_ignored
);

  fr_state_e        st;
  logic             fs_prev;
  logic [1:0]       dly_left;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] bit_idx;
  logic [1:0]       d_eff;
  logic [LEN_W-1:0] len_new;
  logic             start;

  assign d_eff   = eff_delay(cfg_delay);
  assign len_new = LEN_W'(clamp_len(32'(cfg_len), MIN_LEN, WORD_W));

  assign fs_evt     = fs_src & ~fs_prev;
  assign start      = fs_evt && (st == FR_IDLE);
  assign fs_ignored = fs_evt && (st != FR_IDLE);
  assign busy       = (st != FR_IDLE);

  assign sample_en = (start && d_eff == 2'd0) ||
                     (st == FR_WAIT && dly_left == 2'd0) ||
                     (st == FR_SHIFT);
  assign first_bit = sample_en && (st != FR_SHIFT);
  assign last_bit  = (st == FR_SHIFT) && (bit_idx == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FR_IDLE;
      fs_prev  <= 1'b0;
      dly_left <= 2'd0;
      len_q    <= LEN_W'(MIN_LEN);
      bit_idx  <= '0;
    end else begin
      fs_prev <= fs_src;
      case (st)
        FR_IDLE: begin
          if (start) begin
            len_q <= len_new;
            if (d_eff == 2'd0) begin
              st      <= FR_SHIFT;
              bit_idx <= LEN_W'(1);
            end else begin
              st       <= FR_WAIT;
              dly_left <= d_eff - 2'd1;
            end
          end
        end
        FR_WAIT: begin
          if (dly_left == 2'd0) begin
            st      <= FR_SHIFT;
            bit_idx <= LEN_W'(1);
          end else begin
            dly_left <= dly_left - 2'd1;
          end
        end
        FR_SHIFT: begin
          if (last_bit) begin
            st      <= FR_IDLE;
            bit_idx <= '0;
          end else begin
            bit_idx <= bit_idx + LEN_W'(1);
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  // R3: the bit counter never runs past the slot length latched at start.
  assert_bits_within_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_SHIFT) |-> (bit_idx < len_q));

  // R2: the remaining delay never exceeds the longest legal delay.
  assert_delay_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_WAIT) |-> (dly_left < 2'd2));

  // R5: an edge seen mid-slot does not restart the slot.
  assert_busy_edge_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fs_ignored |=> $stable(len_q));

  // R1: after a slot ends, sampling resumes only with a new slot.
  assert_one_slot_per_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> (!sample_en || first_bit));

endmodule

// File: rtl/rx_lane.sv
module rx_lane #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sd,
  input  logic              sample_en,
  input  logic              first_bit,
  input  logic              last_bit,
  input  logic              rd_en,
  output logic [WORD_W-1:0] data,
  output logic              ready,
  output logic              ovr
);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] next_word;
  logic              word_done;

  assign next_word = {shift_q[WORD_W-2:0], sd};
  assign word_done = en && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      data    <= '0;
      ready   <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (en && sample_en)
        shift_q <= first_bit ? WORD_W'(sd) : next_word;
      if (word_done) begin
        data  <= next_word;
        ready <= 1'b1;
        ovr   <= ready && !rd_en;
      end else if (rd_en) begin
        ready <= 1'b0;
        ovr   <= 1'b0;
      end
    end
  end

  // R6: a ready flag only rises from a completed slot.
  assert_ready_from_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(word_done));

  // R6: a read without a new word clears the flag.
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !word_done) |=> !ready);

  // R7: an overrun is only reported over a buffer that was still unread.
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ready));

  // R7: an overrun flag always refers to a word still pending.
  assert_overrun_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> ready);

  // R9: a disabled lane never raises its ready flag.
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ready) |=> !ready);

endmodule

// File: rtl/rx_fsgen.sv
module rx_fsgen #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             busy,
  input  logic [LANES-1:0] ready,
  input  logic [LANES-1:0] lane_en,
  output logic             fs_out
);

  logic all_read;

  assign all_read = ((ready & lane_en) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_out <= 1'b0;
    else        fs_out <= master && !fs_out && !busy && all_read;
  end

  // R8: the generated frame sync lasts exactly one clock.
  assert_fs_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |=> !fs_out);

  // R9: no pulse while an enabled buffer is pending.
  assert_fs_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |-> all_read);

  // R9: no pulse while a slot is still in progress.
  assert_fs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |-> !busy);

endmodule

// File: rtl/burst_rx.sv
module burst_rx #(
  parameter int LANES   = 4,
  parameter int WORD_W  = 32,
  parameter int MIN_LEN = 8,
  parameter int LEN_W   = $clog2(WORD_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_master,
  input  logic [1:0]              cfg_delay,
  input  logic [LEN_W-1:0]        cfg_slot_len,
  input  logic [LANES-1:0]        cfg_lane_en,
  input  logic                    fs_in,
  output logic                    fs_out,
  input  logic [LANES-1:0]        sd_in,
  input  logic [LANES-1:0]        rd_en,
  output logic [LANES*WORD_W-1:0] rd_data,
  output logic [LANES-1:0]        rd_ready,
  output logic [LANES-1:0]        rd_overrun
);

  logic fs_src;
  logic sample_en;
  logic first_bit;
  logic last_bit;
  logic busy;
  logic fs_evt;
  logic fs_ignored;

  // In master mode the framer follows its own pulse; fs_in is not looked at.
  assign fs_src = cfg_master ? fs_out : fs_in;

  rx_framer #(
    .WORD_W (WORD_W),
    .MIN_LEN(MIN_LEN),
    .LEN_W  (LEN_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_src    (fs_src),
    .cfg_delay (cfg_delay),
    .cfg_len   (cfg_slot_len),
    .sample_en (sample_en),
    .first_bit (first_bit),
    .last_bit  (last_bit),
    .busy      (busy),
    .fs_evt    (fs_evt),
    .fs_ignored(fs_ignored)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rx_lane #(.WORD_W(WORD_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_lane_en[i]),
      .sd       (sd_in[i]),
      .sample_en(sample_en),
      .first_bit(first_bit),
      .last_bit (last_bit),
      .rd_en    (rd_en[i]),
      .data     (rd_data[i*WORD_W +: WORD_W]),
      .ready    (rd_ready[i]),
      .ovr      (rd_overrun[i])
    );
  end

  rx_fsgen #(.LANES(LANES)) u_fsgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .master (cfg_master),
    .busy   (busy),
    .ready  (rd_ready),
    .lane_en(cfg_lane_en),
    .fs_out (fs_out)
  );

  // R1: a slot begins only where an edge of the selected frame sync was seen.
  assert_start_on_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (first_bit && !busy) |-> fs_evt);

endmodule

// File: tb/tb_burst_rx.sv
module tb_burst_rx;

  localparam int LANES = 4;
  localparam int W     = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_master = 1'b0;
  logic [1:0]       cfg_delay = 2'd0;
  logic [5:0]       cfg_slot_len = 6'd32;
  logic [3:0]       cfg_lane_en = 4'hF;
  logic             fs_in = 1'b0;
  logic             fs_out;
  logic [3:0]       sd_in = '0;
  logic [3:0]       rd_en = '0;
  logic [127:0]     rd_data;
  logic [3:0]       rd_ready;
  logic [3:0]       rd_overrun;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;

  always #4 clk = ~clk;

  burst_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_delay(cfg_delay),
    .cfg_slot_len(cfg_slot_len), .cfg_lane_en(cfg_lane_en), .fs_in(fs_in),
    .fs_out(fs_out), .sd_in(sd_in), .rd_en(rd_en), .rd_data(rd_data),
    .rd_ready(rd_ready), .rd_overrun(rd_overrun)
  );

  always @(negedge clk) if (fs_out) pulse_cnt++;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int req);
    if (req < 8) return 8;
    if (req > 32) return 32;
    return req;
  endfunction

  function automatic int eff_dly(input int d);
    return (d > 2) ? 2 : d;
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] w, input int len);
    return (len >= 32) ? w : (w & ((32'd1 << len) - 32'd1));
  endfunction

  function automatic logic [31:0] lane_of(input logic [127:0] v, input int l);
    return v[l*32 +: 32];
  endfunction

  // Drive one slot: fs edge at the first step, junk ones during the delay.
  task automatic send_frame(input int d, input int len, input logic [127:0] words,
                            input int extra_fs, input bit hold_fs);
    int de;
    int le;
    de = eff_dly(d);
    le = eff_len(len);
    cfg_delay    = d[1:0];
    cfg_slot_len = len[5:0];
    for (int n = 0; n < de + le; n++) begin
      @(negedge clk);
      fs_in = hold_fs || (n == 0) || (n == extra_fs);
      for (int l = 0; l < LANES; l++) begin
        if (n < de) sd_in[l] = 1'b1;
        else        sd_in[l] = words[l*32 + (le - 1 - (n - de))];
      end
    end
    @(negedge clk);
    fs_in = hold_fs;
    sd_in = '0;
  endtask

  task automatic check_words(input string req, input logic [127:0] words,
                             input int len, input logic [3:0] lanes);
    for (int l = 0; l < LANES; l++)
      if (lanes[l]) check(req, "lane word", lane_of(rd_data, l),
                          keep_low(lane_of(words, l), eff_len(len)));
  endtask

  task automatic read_lanes(input logic [3:0] m);
    @(negedge clk); rd_en = m;
    @(negedge clk); rd_en = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sd_in = sd_in ^ 4'b1011;
    end
    @(negedge clk); sd_in = '0;
  endtask

  task automatic t_reset;
    check("R6", "ready after reset", {28'd0, rd_ready}, 32'd0);
    check("R7", "overrun after reset", {28'd0, rd_overrun}, 32'd0);
    check("R8", "fs_out after reset", {31'd0, fs_out}, 32'd0);
    check("R3", "buffer after reset", lane_of(rd_data, 0), 32'd0);
  endtask

  task automatic t_basic;
    logic [127:0] w = {32'h1357_9BDF, 32'hFEDC_BA98, 32'h0F0F_A5A5, 32'h8000_0001};
    send_frame(1, 32, w, -1, 1'b0);
    check_words("R1", w, 32, 4'hF);
    check("R6", "ready after slot", {28'd0, rd_ready}, 32'hF);
    read_lanes(4'hF);
    check("R6", "ready after read", {28'd0, rd_ready}, 32'h0);
    check("R7", "no overrun", {28'd0, rd_overrun}, 32'h0);
  endtask

  task automatic t_delays;
    for (int d = 0; d < 4; d++) begin
      logic [127:0] w = {32'h0000_00C3 + d, 32'h0000_005A, 32'h0000_0081, 32'h0000_0010 + d};
      send_frame(d, 8, w, -1, 1'b0);
      check_words("R2", w, 8, 4'hF);
      read_lanes(4'hF);
    end
  endtask

  task automatic t_lengths;
    int lens[5] = '{8, 13, 32, 5, 40};
    foreach (lens[k]) begin
      logic [127:0] w = {32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'hC0DE_1234, 32'hFFFF_FFFF ^ k};
      send_frame(0, lens[k], w, -1, 1'b0);
      check_words("R3", w, lens[k], 4'hF);
      read_lanes(4'hF);
    end
  endtask

  task automatic t_idle_and_level;
    logic [127:0] w = {32'h2468_ACE0, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666};
    logic [127:0] w2 = {32'h0BAD_F00D, 32'h0000_FFFF, 32'hFFFF_0000, 32'h9876_5432};
    send_frame(2, 32, w, -1, 1'b0);
    read_lanes(4'hF);
    idle(30);
    check("R4", "ready after idle clocks", {28'd0, rd_ready}, 32'h0);
    check("R4", "overrun after idle clocks", {28'd0, rd_overrun}, 32'h0);
    check_words("R4", w, 32, 4'hF);
    send_frame(0, 32, w2, -1, 1'b1);
    check_words("R1", w2, 32, 4'hF);
    read_lanes(4'hF);
    idle(40);
    check("R1", "held fs gives one slot", {28'd0, rd_ready}, 32'h0);
    fs_in = 1'b0;
  endtask

  task automatic t_fs_mid;
    logic [127:0] w = {32'h0000_A1B2, 32'h0000_C3D4, 32'h0000_E5F6, 32'h0000_0718};
    send_frame(2, 16, w, 6, 1'b0);
    check_words("R5", w, 16, 4'hF);
    read_lanes(4'hF);
    idle(30);
    check("R5", "no slot from mid-shift edge", {28'd0, rd_ready}, 32'h0);
    send_frame(2, 16, ~w, 2, 1'b0);
    check_words("R5", ~w, 16, 4'hF);
    read_lanes(4'hF);
    idle(30);
    check("R5", "no slot from delay-phase edge", {28'd0, rd_ready}, 32'h0);
  endtask

  task automatic t_overrun;
    logic [127:0] w1 = {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444};
    logic [127:0] w2 = {32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003, 32'hDDDD_0004};
    send_frame(1, 32, w1, -1, 1'b0);
    check("R7", "no overrun on first word", {28'd0, rd_overrun}, 32'h0);
    send_frame(1, 32, w2, -1, 1'b0);
    check("R7", "overrun on overwrite", {28'd0, rd_overrun}, 32'hF);
    check_words("R7", w2, 32, 4'hF);
    read_lanes(4'hF);
    check("R7", "overrun cleared by read", {28'd0, rd_overrun}, 32'h0);
    check("R6", "ready cleared by read", {28'd0, rd_ready}, 32'h0);
  endtask

  task automatic t_lane_enable;
    logic [127:0] old = {32'hAAAA_0001, 32'hBBBB_0002, 32'hCCCC_0003, 32'hDDDD_0004};
    logic [127:0] w3 = {32'h5A5A_5A5A, 32'h6B6B_6B6B, 32'h7C7C_7C7C, 32'h8D8D_8D8D};
    cfg_lane_en = 4'b0101;
    send_frame(0, 32, w3, -1, 1'b0);
    check_words("R9", w3, 32, 4'b0101);
    check_words("R9", old, 32, 4'b1010);
    check("R9", "ready only on enabled lanes", {28'd0, rd_ready}, 32'h5);
    read_lanes(4'hF);
    cfg_lane_en = 4'hF;
  endtask

  task automatic t_master;
    logic [127:0] w = {32'h0000_0096, 32'h0000_0069, 32'h0000_00F0, 32'h0000_000F};
    int seen;
    int base;
    cfg_delay = 2'd1;
    cfg_slot_len = 6'd8;
    @(negedge clk); cfg_master = 1'b1;
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (fs_out) seen = 1;
    end
    check("R8", "master pulse issued", seen, 1);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (j == 0) check("R8", "pulse one clock wide", {31'd0, fs_out}, 32'd0);
      for (int l = 0; l < LANES; l++) sd_in[l] = w[l*32 + 7 - j];
    end
    @(negedge clk); sd_in = '0;
    check_words("R8", w, 8, 4'hF);
    base = pulse_cnt;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); fs_in = (i % 4 == 1);
    end
    fs_in = 1'b0;
    check("R9", "no pulse while buffers pending", pulse_cnt - base, 0);
    check("R8", "fs_in ignored in master", {28'd0, rd_overrun}, 32'h0);
    read_lanes(4'b0111);
    idle(5);
    check("R9", "no pulse with one buffer pending", pulse_cnt - base, 0);
    read_lanes(4'b1000);
    for (int i = 0; i < 2; i++) @(negedge clk);
    check("R9", "pulse after last read", pulse_cnt - base, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_delays();
    t_lengths();
    t_idle_and_level();
    t_fs_mid();
    t_overrun();
    t_lane_enable();
    t_master();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule